// File: doc/BRIEF.md
# Sector Erase Sequencer with Zero Preprogram

This block runs the internal erase algorithm of a small flash-like bank that is modelled as a word-addressed array. A single-cycle start request names the sectors to clear. It names them either through a bitmap or through a whole-bank flag, and a protect vector removes sectors from that set. Every sector that is left gets three passes. The first pass writes zero into each word. The second pass reads each word back and confirms that it is zero. The last pass writes all ones into each word. Sectors run one after another from the lowest index up, and each pass handles one word per clock.

While the sequence runs, the bank answers reads with a status word in place of array data. That status word carries a polling bit and a toggle bit. Host writes and new start requests are dropped for as long as the bank is busy. When the last sector finishes, a one-cycle done pulse appears, the ready output rises in the same cycle, and reads return array contents again. A synchronous hardware reset stops the sequence at the current word. Whatever has already been written stays in place, so a partly processed sector must be erased again.

Top module: `erase_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `ready` = 1 and `done` = 0. Array contents are not cleared by reset.
- R2: If a start request has at least one eligible sector, `ready` falls in the cycle after start and stays low for exactly 3 × SECT_WORDS cycles per eligible sector. `done` is high for exactly one cycle, and it is the same cycle in which `ready` returns to 1.
- R3: Once a sequence completes, every word of each eligible sector reads 16'hFFFF.
- R4: Sectors that are protected, and sectors that were not selected, keep their contents through the sequence.
- R5: When `whole_chip` = 1, `sect_sel` is ignored and every sector not marked in `protect` becomes eligible.
- R6: Eligible sectors are handled in ascending index order. Sector s covers addresses s × SECT_WORDS up to s × SECT_WORDS + SECT_WORDS − 1. A reset in the middle of a sequence stops it at once, and lower sectors that already finished stay erased.
- R7: Before the erase pass, each word of a sector is written to zero. After a reset during that sector's verify pass, its words read 0.
- R8: While `ready` = 0, `host_we` and `start` have no effect on the array or on the sequence length.
- R9: A read issued while `ready` = 0 returns a status word in which bit 7 = 0, bit 6 = the toggle bit and all other bits are 0. The toggle bit is 0 after reset and flips after each such read.
- R10: If a start request has no eligible sector, `done` pulses in the cycle after start and `ready` stays 1.
- R11: While `ready` = 1, `rd_data` shows the array word at `rd_addr` in the cycle after `rd_en`, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| start | input | 1 | One-cycle erase request |
| sect_sel | input | NUM_SECT | Bitmap of sectors to erase |
| whole_chip | input | 1 | Erase all unprotected sectors |
| protect | input | NUM_SECT | Per-sector protection, 1 = skip |
| host_we | input | 1 | Array write strobe (idle only) |
| host_addr | input | AW | Array write address |
| host_wdata | input | DATA_W | Array write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Read address |
| rd_data | output | DATA_W | Registered read data or status word |
| ready | output | 1 | 1 = idle, 0 = sequence running |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench attacks the points where a sequencer most easily slips. It runs a mix of protected and selected sectors, where a wrong mask would erase a guarded sector or skip a chosen one. It uses a whole-bank request with a stale bitmap, which catches a design that still honours `sect_sel`. It issues an empty request, where a faulty design would go busy or never signal done. It resets the bank partway through a two-sector run and then inspects the array. If the sectors had been taken in the wrong order, or the zero pass had been skipped, the lower sector would not be all ones or the upper one would not be all zeros. Writes, restarts and status reads during busy confirm that late commands are dropped, that the length of the busy window is exact, and that the toggle bit alternates.

// File: rtl/erase_pkg.sv
// Shared types for the erase sequencer.
// Assumes nothing beyond a standard SystemVerilog package scope.
package erase_pkg;
    // Controller phase: idle, zero program, zero verify, erase to ones
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PROG   = 2'd1,
        ST_VERIFY = 2'd2,
        ST_ERASE  = 2'd3
    } erase_st_e;
endpackage

// File: rtl/erase_array.sv
// Behavioural word array with one write port and two combinational read
// ports. Assumes a single writer per cycle; contents are never reset.
module erase_array #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 32,
    parameter int AW     = 5
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    logic [DATA_W-1:0] cells [DEPTH];

    // Store one word on a write strobe
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    // Unregistered reads for the verify pass and the host path
    assign rdata_a = cells[raddr_a];
    assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/erase_pick.sv
// Lowest-set-bit encoder over a sector mask.
// Assumes NUM_SECT >= 2; idx is don't-care when any is low.
module erase_pick #(
    parameter int NUM_SECT = 4,
    localparam int SIW     = $clog2(NUM_SECT)
) (
    input  logic [NUM_SECT-1:0] mask,
    output logic [SIW-1:0]      idx,
    output logic                any
);
    // Scan from the top so the lowest set bit wins
    always_comb begin
        idx = '0;
        for (int i = NUM_SECT - 1; i >= 0; i--) begin
            if (mask[i]) idx = SIW'(i);
        end
        any = |mask;
    end
endmodule

// File: rtl/erase_ctrl.sv
// Erase sequencer FSM. Walks the pending sectors lowest index first and
// runs three passes of SECT_WORDS cycles each: write zero, check zero,
// write ones. A failed check restarts the zero pass of that sector.
// Assumes the verify data is the combinational array word at addr.
module erase_ctrl
    import erase_pkg::*;
#(
    parameter int NUM_SECT   = 4,
    parameter int SECT_WORDS = 8,
    parameter int DATA_W     = 16,
    parameter int AW         = 5,
    localparam int SIW       = $clog2(NUM_SECT),
    localparam int WW        = $clog2(SECT_WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [NUM_SECT-1:0] targets,
    input  logic [DATA_W-1:0]   vdata,
    output logic                busy,
    output logic                done,
    output logic                we,
    output logic [AW-1:0]       addr,
    output logic [DATA_W-1:0]   wdata
);
    erase_st_e           state;
    logic [NUM_SECT-1:0] pending;
    logic [NUM_SECT-1:0] pick_in;
    logic [SIW-1:0]      cur;
    logic [SIW-1:0]      pick_idx;
    logic                pick_any;
    logic [WW-1:0]       word;
    logic                last_word;

    // Candidate mask: fresh targets when idle, else the rest after cur
    always_comb begin
        if (state == ST_IDLE) pick_in = targets;
        else                  pick_in = pending & ~(NUM_SECT'(1) << cur);
    end

    erase_pick #(.NUM_SECT(NUM_SECT)) u_pick (
        .mask (pick_in),
        .idx  (pick_idx),
        .any  (pick_any)
    );

    // Address and write data for the current word
    assign last_word = (word == WW'(SECT_WORDS - 1));
    assign addr      = AW'(cur) * AW'(SECT_WORDS) + AW'(word);
    assign we        = (state == ST_PROG) || (state == ST_ERASE);
    assign wdata     = (state == ST_ERASE) ? '1 : '0;

    // Phase, sector and word sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            busy    <= 1'b0;
            done    <= 1'b0;
            pending <= '0;
            cur     <= '0;
            word    <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        pending <= targets;
                        word    <= '0;
                        if (pick_any) begin
                            cur   <= pick_idx;
                            state <= ST_PROG;
                            busy  <= 1'b1;
                        end else begin
                            done  <= 1'b1;
                        end
                    end
                end
                ST_PROG: begin
                    if (last_word) begin
                        word  <= '0;
                        state <= ST_VERIFY;
                    end else begin
                        word  <= word + 1'b1;
                    end
                end
                ST_VERIFY: begin
                    if (vdata != '0) begin
                        word  <= '0;
                        state <= ST_PROG;
                    end else if (last_word) begin
                        word  <= '0;
                        state <= ST_ERASE;
                    end else begin
                        word  <= word + 1'b1;
                    end
                end
                ST_ERASE: begin
                    if (last_word) begin
                        word    <= '0;
                        pending <= pick_in;
                        if (pick_any) begin
                            cur   <= pick_idx;
                            state <= ST_PROG;
                        end else begin
                            state <= ST_IDLE;
                            busy  <= 1'b0;
                            done  <= 1'b1;
                        end
                    end else begin
                        word <= word + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/erase_seq.sv
// Top of the erase sequencer. Masks the request with the protect vector,
// gives the array write port to the controller while busy (host writes are
// dropped then), and answers reads with a status word while busy.
// Assumes DATA_W >= 8 so that status bits 7 and 6 exist.
module erase_seq #(
    parameter int NUM_SECT   = 4,
    parameter int SECT_WORDS = 8,
    parameter int DATA_W     = 16,
    localparam int DEPTH     = NUM_SECT * SECT_WORDS,
    localparam int AW        = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [NUM_SECT-1:0] sect_sel,
    input  logic                whole_chip,
    input  logic [NUM_SECT-1:0] protect,
    input  logic                host_we,
    input  logic [AW-1:0]       host_addr,
    input  logic [DATA_W-1:0]   host_wdata,
    input  logic                rd_en,
    input  logic [AW-1:0]       rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    output logic                ready,
    output logic                done
);
    localparam logic [DATA_W-1:0] ERASED = '1;

    logic [NUM_SECT-1:0] targets;
    logic                busy;
    logic                ctl_we;
    logic [AW-1:0]       ctl_addr;
    logic [DATA_W-1:0]   ctl_wdata;
    logic                arr_we;
    logic [AW-1:0]       arr_waddr;
    logic [DATA_W-1:0]   arr_wdata;
    logic [DATA_W-1:0]   vdata;
    logic [DATA_W-1:0]   host_rdata;
    logic [DATA_W-1:0]   status;
    logic                toggle;

    // Eligible sectors for a request
    assign targets = (whole_chip ? {NUM_SECT{1'b1}} : sect_sel) & ~protect;

    erase_ctrl #(
        .NUM_SECT   (NUM_SECT),
        .SECT_WORDS (SECT_WORDS),
        .DATA_W     (DATA_W),
        .AW         (AW)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .targets (targets),
        .vdata   (vdata),
        .busy    (busy),
        .done    (done),
        .we      (ctl_we),
        .addr    (ctl_addr),
        .wdata   (ctl_wdata)
    );

    // Write port ownership: controller while busy, host otherwise
    always_comb begin
        if (busy) begin
            arr_we    = ctl_we;
            arr_waddr = ctl_addr;
            arr_wdata = ctl_wdata;
        end else begin
            arr_we    = host_we;
            arr_waddr = host_addr;
            arr_wdata = host_wdata;
        end
    end

    erase_array #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .AW     (AW)
    ) u_array (
        .clk     (clk),
        .we      (arr_we),
        .waddr   (arr_waddr),
        .wdata   (arr_wdata),
        .raddr_a (ctl_addr),
        .rdata_a (vdata),
        .raddr_b (rd_addr),
        .rdata_b (host_rdata)
    );

    // Status word: inverted erased value on bit 7, toggle on bit 6
    always_comb begin
        status    = '0;
        status[7] = ~ERASED[7];
        status[6] = toggle;
    end

    // Registered read path and toggle flip per status read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            toggle  <= 1'b0;
        end else if (rd_en) begin
            if (busy) begin
                rd_data <= status;
                toggle  <= ~toggle;
            end else begin
                rd_data <= host_rdata;
            end
        end
    end

    assign ready = ~busy;
endmodule

// File: rtl/erase_seq_chk.sv
// Checker for erase_seq, attached by bind. Observes the top ports plus
// the busy flag and the shared array write port.
module erase_seq_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              arr_we,
    input logic [DATA_W-1:0] arr_wdata
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done));

    // R2
    done_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R2
    busy_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(rst_n)) |-> done);

    // R2
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && $past(rst_n)) |-> $past(start));

    // R3
    busy_write_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && arr_we) |-> (arr_wdata == '0 || arr_wdata == '1));

    // R9
    poll_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_en) |=> (rd_data[7] == 1'b0));

    // R9
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_en && $past(busy && rd_en) && $past(rst_n))
        |=> (rd_data[6] != $past(rd_data[6])));

    // R11
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rd_en)) |-> $stable(rd_data));
endmodule

bind erase_seq erase_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .arr_we    (arr_we),
    .arr_wdata (arr_wdata)
);

// File: tb/erase_seq_bench.sv
// Scoreboard bench for erase_seq: the driver pushes expected read words,
// a monitor pops and compares them one cycle after each read strobe.
module erase_seq_bench;
    localparam int NS    = 4;
    localparam int SW    = 8;
    localparam int DW    = 16;
    localparam int DEPTH = NS * SW;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NS-1:0] sect_sel = '0;
    logic          whole_chip = 1'b0;
    logic [NS-1:0] protect = '0;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          ready;
    logic          done;

    erase_seq #(.NUM_SECT(NS), .SECT_WORDS(SW), .DATA_W(DW)) u_erase_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .sect_sel   (sect_sel),
        .whole_chip (whole_chip),
        .protect    (protect),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .ready      (ready),
        .done       (done)
    );

    always #5 clk = ~clk;

    int            checks = 0;
    int            fails = 0;
    bit            finished = 1'b0;
    int            busy_cnt = 0;
    int            done_cnt = 0;
    bit            tgl = 1'b0;
    bit            rd_seen = 1'b0;
    bit            prev_done = 1'b0;
    logic [DW-1:0] model [DEPTH];
    logic [DW-1:0] exp_q [$];
    string         tag_q [$];

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Monitor: note which cycles carry a read
    always @(posedge clk) rd_seen <= rd_en;

    // Monitor: pop and compare read results, track busy and done
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [DW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(rd_data === e, t, rd_data, e);
        end
        if (rst_n) begin
            if (!ready) busy_cnt++;
            if (done) begin
                done_cnt++;
                // R2: done only while ready, never two cycles long
                chk(ready === 1'b1 && !prev_done, "R2", {ready, prev_done}, 2'b10);
            end
        end
        prev_done = done;
    end

    task automatic rd(input int a, input logic [DW-1:0] e, input string tag);
        @(negedge clk);
        rd_en   = 1'b1;
        rd_addr = AW'(a);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d, input bit upd);
        @(negedge clk);
        host_we    = 1'b1;
        host_addr  = AW'(a);
        host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
        if (upd) model[a] = d;
    endtask

    task automatic fill();
        for (int a = 0; a < DEPTH; a++) wr(a, DW'(16'hA500 ^ a), 1'b1);
    endtask

    task automatic mark(input logic [NS-1:0] m, input logic [DW-1:0] v);
        for (int a = 0; a < DEPTH; a++)
            if (m[a / SW]) model[a] = v;
    endtask

    task automatic check_all(input logic [NS-1:0] changed,
                             input string tag_c, input string tag_k);
        for (int a = 0; a < DEPTH; a++)
            rd(a, model[a], changed[a / SW] ? tag_c : tag_k);
        @(negedge clk);
    endtask

    task automatic wait_done(input int prev);
        int n = 0;
        while (done_cnt == prev && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_op(input logic [NS-1:0] sel, input bit wc,
                          input logic [NS-1:0] prot, input int nsect,
                          input string tag, input bit extras);
        int prev;
        prev     = done_cnt;
        @(negedge clk);
        busy_cnt   = 0;
        sect_sel   = sel;
        whole_chip = wc;
        protect    = prot;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (extras) begin
            // R9: two status reads while busy, toggle alternates
            rd(0, tgl ? DW'(16'h0040) : DW'(16'h0000), "R9");
            tgl = ~tgl;
            rd(0, tgl ? DW'(16'h0040) : DW'(16'h0000), "R9");
            tgl = ~tgl;
            // R8: host write and restart during busy are dropped
            wr(3 * SW + 1, DW'(16'h1234), 1'b0);
            @(negedge clk);
            sect_sel = 4'b1000;
            start    = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done(prev);
        chk(done_cnt == prev + 1, "R2", done_cnt, prev + 1);
        chk(busy_cnt == 3 * SW * nsect, tag, busy_cnt, 3 * SW * nsect);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    // Driver
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(ready === 1'b1, "R1", ready, 1);
        chk(done === 1'b0, "R1", done, 0);
        rst_n = 1'b1;
        tgl   = 1'b0;

        // R11: array readback when idle
        fill();
        check_all('0, "R11", "R11");

        // Sector 0 only, with status reads and dropped commands (R2, R8, R9)
        run_op(4'b0001, 1'b0, 4'b0000, 1, "R2", 1'b1);
        mark(4'b0001, '1);
        check_all(4'b0001, "R3", "R8");

        // Whole bank with stale bitmap and sector 2 protected (R5, R4)
        fill();
        run_op(4'b0001, 1'b1, 4'b0100, 3, "R5", 1'b0);
        mark(4'b1011, '1);
        check_all(4'b1011, "R5", "R4");

        // Sector bitmap with one selected sector protected (R4)
        fill();
        run_op(4'b0011, 1'b0, 4'b0010, 1, "R4", 1'b0);
        mark(4'b0001, '1);
        check_all(4'b0001, "R3", "R4");

        // Request with no eligible sector (R10)
        run_op(4'b0100, 1'b0, 4'b0100, 0, "R10", 1'b0);

        // Reset during sector 2 verify of a sectors 1+2 run (R6, R7)
        fill();
        @(negedge clk);
        sect_sel   = 4'b0110;
        whole_chip = 1'b0;
        protect    = 4'b0000;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4 * SW + 1) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tgl   = 1'b0;
        // R1: reset drops busy at once
        chk(ready === 1'b1, "R1", ready, 1);
        chk(done === 1'b0, "R1", done, 0);
        mark(4'b0010, '1);
        mark(4'b0100, '0);
        check_all(4'b0010, "R6", "R7");

        finish_run();
    end
endmodule